// File: doc/BRIEF.md
# Parallel-Port IDE Register Sequencer

This block lets a host reach one register of an IDE drive through a legacy parallel port and a bridge adapter. It owns the port's eight data lines and four control lines, and it watches the four upper status lines. A request names an operation, a bank (task-file registers or command-block registers), a register index and, for writes, a data byte. The block then plays out a fixed series of data and control steps on the port. A read returns one byte built from two status nibbles.

Four operations exist. A read and a write each touch one register. A connect records the port's present data and control values and parks control at the idle value. A disconnect sends a release address and then puts back the recorded values. Each step is held on the lines for a run-time number of clock cycles, so the block can match slow adapters. One request runs at a time. A one-cycle done pulse marks the end of each request.

Top module: `ppide_reg_seq`

## Requirements
- R1: The address byte of a read or write is the register index added to 0x08 when `req_bank`=0, or to 0x10 when `req_bank`=1.
- R2: `req_op` is encoded as 00 read, 01 write, 10 connect, 11 disconnect. A read or write starts with control 0x4, then drives its address byte on the data lines, then steps control through 0xC, 0xE, 0xE, 0xC, 0x4, 0x4, 0x4.
- R3: After the address pattern, a read sets control to 0x6, then to 0x4, then to 0x4 again, so it finishes with control at 0x4. Status is sampled in the last cycle of the 0x6 step (low sample) and in the last cycle of the first 0x4 step after it (high sample).
- R4: `pp_status` carries status lines 7..4. A read returns `rsp_rdata[3:0]` equal to the low sample and `rsp_rdata[7:4]` equal to the high sample.
- R5: After the address pattern, a write drives `req_wdata` on the data lines, then steps control through 0x5, 0x7, 0x5, 0x4.
- R6: A connect records the data and control outputs as they were before it, then sets control to 0x4 in one step.
- R7: A disconnect sets control to 0x4, drives address 0x20, runs the same seven-step control pattern, then drives the recorded data byte and then the recorded control value.
- R8: Every step holds for `step_hold` cycles, where a value of 0 counts as 1. The value is captured when the request is accepted.
- R9: A start that arrives while a request is in progress is ignored. The running sequence continues unchanged, whatever the other request inputs show.
- R10: `rsp_done` is high for exactly one cycle, in the cycle right after the hold of the final step ends. `rsp_rdata` keeps its value until the next read completes. While idle with no start, the port outputs do not change.
- R11: After reset the data lines are 0x00, control is 0xC, `rsp_done` is 0 and `rsp_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request pulse, accepted when idle |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 connect, 11 disconnect |
| req_bank | input | 1 | 0 task-file registers, 1 command-block registers |
| req_idx | input | IDX_W | Register index |
| req_wdata | input | 8 | Byte to write |
| step_hold | input | HOLD_W | Cycles per step (0 counts as 1) |
| pp_data | output | 8 | Parallel-port data lines |
| pp_ctrl | output | 4 | Parallel-port control lines |
| pp_status | input | 4 | Status lines 7..4 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte assembled by the last read |

## Verification
The assertions check these rules on every cycle:
- `rsp_done` never lasts more than one cycle, and it never appears without a request that just finished.
- The port lines move only at step boundaries.
- A start received while busy leaves the step index in place.
- A read ends with control at 0x4.
- A disconnect ends with the recorded lines restored.
- The hold counter stays below its limit.

Other properties can only be shown by the bench scenarios, which compare every cycle of the port lines against a model:
- the exact order of the steps;
- the address arithmetic for each bank;
- the nibble packing of the read byte;
- hold values of 0, 1, 3 and 5;
- the values recorded by connect and put back by disconnect after different port histories.

// File: rtl/ppide_pkg.sv
package ppide_pkg;

   typedef enum logic [1:0] {
      OP_READ       = 2'b00,
      OP_WRITE      = 2'b01,
      OP_CONNECT    = 2'b10,
      OP_DISCONNECT = 2'b11
   } op_e;

   // What a step does to the port, and whether status is captured at its end
   typedef enum logic [1:0] {
      ST_CTRL    = 2'b00,
      ST_DATA    = 2'b01,
      ST_CTRL_LO = 2'b10,
      ST_CTRL_HI = 2'b11
   } step_kind_e;

   typedef struct packed {
      step_kind_e kind;
      logic [7:0] val;
      logic       last;
   } step_t;

   // Address strobe pattern shared by read, write and disconnect
   function automatic logic [3:0] strobe_ctl(input logic [3:0] pos);
      case (pos)
         4'd0:    strobe_ctl = 4'hC;
         4'd1:    strobe_ctl = 4'hE;
         4'd2:    strobe_ctl = 4'hE;
         4'd3:    strobe_ctl = 4'hC;
         default: strobe_ctl = 4'h4;
      endcase
   endfunction

endpackage

// File: rtl/ppide_step_gen.sv
module ppide_step_gen
   import ppide_pkg::*;
#(
   parameter int          IDX_W      = 3,
   parameter logic [7:0]  BANK0_BASE = 8'h08,
   parameter logic [7:0]  BANK1_BASE = 8'h10,
   parameter logic [7:0]  DISC_ADDR  = 8'h20
) (
   input  op_e              op,
   input  logic             bank,
   input  logic [IDX_W-1:0] idx,
   input  logic [3:0]       seq,
   input  logic [7:0]       wval,
   input  logic [7:0]       sv_data,
   input  logic [3:0]       sv_ctrl,
   output step_t            step
);

   localparam int PAD_W = 8 - IDX_W;

   logic [7:0] addr;
   logic [3:0] pat_pos;

   assign addr    = (bank ? BANK1_BASE : BANK0_BASE) + {{PAD_W{1'b0}}, idx};
   assign pat_pos = seq - 4'd2;

   always_comb begin
      step = '{kind: ST_CTRL, val: 8'h04, last: 1'b0};
      if (op == OP_CONNECT) begin
         step.last = 1'b1;
      end else if (seq == 4'd0) begin
         step.val = 8'h04;
      end else if (seq == 4'd1) begin
         step.kind = ST_DATA;
         step.val  = (op == OP_DISCONNECT) ? DISC_ADDR : addr;
      end else if (seq <= 4'd8) begin
         step.val = {4'h0, strobe_ctl(pat_pos)};
      end else begin
         case (op)
            OP_READ: begin
               case (seq)
                  4'd9:    step = '{kind: ST_CTRL_LO, val: 8'h06, last: 1'b0};
                  4'd10:   step = '{kind: ST_CTRL_HI, val: 8'h04, last: 1'b0};
                  default: step = '{kind: ST_CTRL,    val: 8'h04, last: 1'b1};
               endcase
            end
            OP_WRITE: begin
               case (seq)
                  4'd9:    step = '{kind: ST_DATA, val: wval,  last: 1'b0};
                  4'd10:   step = '{kind: ST_CTRL, val: 8'h05, last: 1'b0};
                  4'd11:   step = '{kind: ST_CTRL, val: 8'h07, last: 1'b0};
                  4'd12:   step = '{kind: ST_CTRL, val: 8'h05, last: 1'b0};
                  default: step = '{kind: ST_CTRL, val: 8'h04, last: 1'b1};
               endcase
            end
            default: begin
               if (seq == 4'd9) step = '{kind: ST_DATA, val: sv_data, last: 1'b0};
               else             step = '{kind: ST_CTRL, val: {4'h0, sv_ctrl}, last: 1'b1};
            end
         endcase
      end
   end

endmodule

// File: rtl/ppide_hold_timer.sv
module ppide_hold_timer #(
   parameter int HOLD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              run,
   input  logic [HOLD_W-1:0] hold_in,
   output logic              tick
);

   localparam logic [HOLD_W-1:0] ONE = {{(HOLD_W-1){1'b0}}, 1'b1};

   logic [HOLD_W-1:0] hold_q;
   logic [HOLD_W-1:0] cnt_q;

   assign tick = run && (cnt_q == hold_q - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= ONE;
         cnt_q  <= '0;
      end else if (load) begin
         hold_q <= (hold_in == '0) ? ONE : hold_in;
         cnt_q  <= '0;
      end else if (run) begin
         cnt_q  <= tick ? '0 : cnt_q + ONE;
      end
   end

   // R8: the hold counter never passes the captured hold length
   a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < hold_q);

endmodule

// File: rtl/ppide_nibble_join.sv
module ppide_nibble_join #(
   parameter int NIB_W = 4
) (
   input  logic [NIB_W-1:0]   lo_nib,
   input  logic [NIB_W-1:0]   hi_nib,
   output logic [2*NIB_W-1:0] byte_out
);

   for (genvar i = 0; i < NIB_W; i++) begin : g_bit
      assign byte_out[i]         = lo_nib[i];
      assign byte_out[NIB_W + i] = hi_nib[i];
   end

endmodule

// File: rtl/ppide_reg_seq.sv
module ppide_reg_seq
   import ppide_pkg::*;
#(
   parameter int          IDX_W      = 3,
   parameter int          HOLD_W     = 4,
   parameter logic [7:0]  RST_DATA   = 8'h00,
   parameter logic [3:0]  RST_CTRL   = 4'hC,
   parameter logic [7:0]  BANK0_BASE = 8'h08,
   parameter logic [7:0]  BANK1_BASE = 8'h10,
   parameter logic [7:0]  DISC_ADDR  = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [1:0]        req_op,
   input  logic              req_bank,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [7:0]        req_wdata,
   input  logic [HOLD_W-1:0] step_hold,
   output logic [7:0]        pp_data,
   output logic [3:0]        pp_ctrl,
   input  logic [3:0]        pp_status,
   output logic              rsp_done,
   output logic [7:0]        rsp_rdata
);

   if (IDX_W < 1 || IDX_W > 3) begin : g_bad_idx
      $error("ppide_reg_seq: IDX_W must lie in 1..3");
   end
   if (HOLD_W < 1 || HOLD_W > 16) begin : g_bad_hold
      $error("ppide_reg_seq: HOLD_W must lie in 1..16");
   end

   logic             busy_q;
   op_e              op_q;
   logic             bank_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       wdata_q;
   logic [3:0]       seq_q;
   step_kind_e       kind_q;
   logic             last_q;
   logic [7:0]       pd_q, sv_data_q;
   logic [3:0]       pc_q, sv_ctrl_q;
   logic [3:0]       lo_q, hi_q;
   logic [7:0]       rdata_q;
   logic             done_q;

   logic             accept, tick;
   op_e              g_op;
   logic             g_bank;
   logic [IDX_W-1:0] g_idx;
   logic [7:0]       g_wval;
   logic [3:0]       g_seq;
   step_t            nstep;
   logic [7:0]       joined;

   assign accept = req_start && !busy_q;

   // Idle: look at the incoming request; busy: look at the latched one
   assign g_op   = busy_q ? op_q    : op_e'(req_op);
   assign g_bank = busy_q ? bank_q  : req_bank;
   assign g_idx  = busy_q ? idx_q   : req_idx;
   assign g_wval = busy_q ? wdata_q : req_wdata;
   assign g_seq  = busy_q ? seq_q + 4'd1 : 4'd0;

   ppide_step_gen #(
      .IDX_W(IDX_W), .BANK0_BASE(BANK0_BASE),
      .BANK1_BASE(BANK1_BASE), .DISC_ADDR(DISC_ADDR)
   ) u_step_gen (
      .op(g_op), .bank(g_bank), .idx(g_idx), .seq(g_seq), .wval(g_wval),
      .sv_data(sv_data_q), .sv_ctrl(sv_ctrl_q), .step(nstep)
   );

   ppide_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(accept), .run(busy_q),
      .hold_in(step_hold), .tick(tick)
   );

   ppide_nibble_join #(.NIB_W(4)) u_join (
      .lo_nib(lo_q), .hi_nib(hi_q), .byte_out(joined)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         op_q      <= OP_READ;
         bank_q    <= 1'b0;
         idx_q     <= '0;
         wdata_q   <= '0;
         seq_q     <= '0;
         kind_q    <= ST_CTRL;
         last_q    <= 1'b0;
         pd_q      <= RST_DATA;
         pc_q      <= RST_CTRL;
         sv_data_q <= RST_DATA;
         sv_ctrl_q <= RST_CTRL;
         lo_q      <= '0;
         hi_q      <= '0;
         rdata_q   <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            op_q    <= op_e'(req_op);
            bank_q  <= req_bank;
            idx_q   <= req_idx;
            wdata_q <= req_wdata;
            seq_q   <= '0;
            kind_q  <= nstep.kind;
            last_q  <= nstep.last;
            if (op_e'(req_op) == OP_CONNECT) begin
               sv_data_q <= pd_q;
               sv_ctrl_q <= pc_q;
            end
            if (nstep.kind == ST_DATA) pd_q <= nstep.val;
            else                       pc_q <= nstep.val[3:0];
         end else if (busy_q && tick) begin
            if (kind_q == ST_CTRL_LO) lo_q <= pp_status;
            if (kind_q == ST_CTRL_HI) hi_q <= pp_status;
            if (last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               if (op_q == OP_READ) rdata_q <= joined;
            end else begin
               seq_q  <= seq_q + 4'd1;
               kind_q <= nstep.kind;
               last_q <= nstep.last;
               if (nstep.kind == ST_DATA) pd_q <= nstep.val;
               else                       pc_q <= nstep.val[3:0];
            end
         end
      end
   end

   assign pp_data   = pd_q;
   assign pp_ctrl   = pc_q;
   assign rsp_done  = done_q;
   assign rsp_rdata = rdata_q;

   // R10: done is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R10: quiet while idle and not started
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !req_start) |=> ($stable(pd_q) && $stable(pc_q) && !done_q));

   // R8: port lines only move when a step's hold runs out
   a_r8_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !tick) |=> ($stable(pd_q) && $stable(pc_q)));

   // R9: a start while busy does not move or restart the step index
   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && req_start && !tick) |=> ($stable(seq_q) && busy_q));

   // R3: a read finishes with control at 0x4
   a_r3_read_end_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && op_q == OP_READ) |-> (pc_q == 4'h4));

   // R7: a disconnect finishes with recorded lines restored
   a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && op_q == OP_DISCONNECT) |-> (pd_q == sv_data_q && pc_q == sv_ctrl_q));

endmodule

// File: tb/ppide_reg_seq_tb.sv
module ppide_reg_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_start = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic       req_bank = 1'b0;
   logic [2:0] req_idx = '0;
   logic [7:0] req_wdata = '0;
   logic [3:0] step_hold = 4'd2;
   logic [7:0] pp_data;
   logic [3:0] pp_ctrl;
   logic [3:0] pp_status;
   logic       rsp_done;
   logic [7:0] rsp_rdata;

   logic [3:0] st_lo = 4'h0, st_hi = 4'h0;

   int checks = 0;
   int errors = 0;

   // Scoreboard: expected {data,ctrl} per cycle, and expected read byte
   logic [11:0] tr_q[$];
   logic [7:0]  m_pd = 8'h00, m_sd = 8'h00, m_rd = 8'h00;
   logic [3:0]  m_pc = 4'hC, m_sc = 4'hC;
   string       cur_tag = "";
   bit          active = 1'b0;
   bit          fin = 1'b0;

   always #5 clk = ~clk;

   // Adapter model: status nibble depends on the control lines
   assign pp_status = (pp_ctrl == 4'h6) ? st_lo : st_hi;

   ppide_reg_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
      .req_bank(req_bank), .req_idx(req_idx), .req_wdata(req_wdata),
      .step_hold(step_hold), .pp_data(pp_data), .pp_ctrl(pp_ctrl),
      .pp_status(pp_status), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic add_step(input bit is_data, input logic [7:0] v, input int h);
      if (is_data) m_pd = v;
      else         m_pc = v[3:0];
      for (int c = 0; c < h; c++) tr_q.push_back({m_pd, m_pc});
   endtask

   task automatic build(input logic [1:0] op, input logic bank, input logic [2:0] idx,
                        input logic [7:0] wv, input int hold);
      int h;
      logic [7:0] addr;
      h = (hold == 0) ? 1 : hold;
      addr = (bank ? 8'h10 : 8'h08) + {5'b0, idx};
      if (op == 2'b10) begin
         m_sd = m_pd; m_sc = m_pc;
         add_step(0, 8'h04, h);
         return;
      end
      add_step(0, 8'h04, h);
      add_step(1, (op == 2'b11) ? 8'h20 : addr, h);
      add_step(0, 8'h0C, h); add_step(0, 8'h0E, h); add_step(0, 8'h0E, h);
      add_step(0, 8'h0C, h); add_step(0, 8'h04, h); add_step(0, 8'h04, h);
      add_step(0, 8'h04, h);
      case (op)
         2'b00: begin
            add_step(0, 8'h06, h); add_step(0, 8'h04, h); add_step(0, 8'h04, h);
            m_rd = {st_hi, st_lo};
         end
         2'b01: begin
            add_step(1, wv, h);
            add_step(0, 8'h05, h); add_step(0, 8'h07, h);
            add_step(0, 8'h05, h); add_step(0, 8'h04, h);
         end
         default: begin
            add_step(1, m_sd, h);
            add_step(0, {4'h0, m_sc}, h);
         end
      endcase
   endtask

   // Driver: pushes expectations, issues the request, optionally a stray start
   task automatic do_op(input logic [1:0] op, input logic bank, input logic [2:0] idx,
                        input logic [7:0] wv, input logic [3:0] hold, input bit stray,
                        input string tag);
      @(negedge clk);
      cur_tag = tag;
      build(op, bank, idx, wv, int'(hold));
      req_op = op; req_bank = bank; req_idx = idx; req_wdata = wv; step_hold = hold;
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      if (stray) begin
         repeat (4) @(negedge clk);
         req_op = 2'b01; req_bank = 1'b1; req_idx = 3'd5; req_wdata = 8'hFF;
         step_hold = 4'd1; req_start = 1'b1;
         @(negedge clk);
         req_start = 1'b0;
      end
      wait (fin);
      fin = 1'b0;
   endtask

   // Monitor: compares each cycle of the port against the queue
   initial begin
      logic [11:0] w;
      forever begin
         @(posedge clk);
         if (!active && req_start && rst_n) active = 1'b1;
         @(negedge clk);
         if (active) begin
            if (tr_q.size() > 0) begin
               w = tr_q.pop_front();
               chk({pp_data, pp_ctrl} == w, cur_tag, {20'h0, pp_data, pp_ctrl}, {20'h0, w});
               chk(rsp_done == 1'b0, "R10 early done", rsp_done, 0);
            end else begin
               chk(rsp_done == 1'b1, "R10 done pulse", rsp_done, 1);
               chk(rsp_rdata == m_rd, "R4 R10 read byte", rsp_rdata, m_rd);
               active = 1'b0;
               fin = 1'b1;
            end
         end else if (rst_n) begin
            chk(rsp_done == 1'b0, "R10 stray done", rsp_done, 0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset values
      chk(pp_data == 8'h00, "R11 data", pp_data, 8'h00);
      chk(pp_ctrl == 4'hC, "R11 ctrl", pp_ctrl, 4'hC);
      chk(rsp_done == 1'b0, "R11 done", rsp_done, 0);
      chk(rsp_rdata == 8'h00, "R11 rdata", rsp_rdata, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_op(2'b10, 0, 3'd0, 8'h00, 4'd2, 0, "R6 connect");
      st_lo = 4'hA; st_hi = 4'h3;
      do_op(2'b00, 0, 3'd2, 8'h00, 4'd2, 0, "R1 R2 R3 read bank0");
      st_lo = 4'hF; st_hi = 4'h0;
      do_op(2'b00, 1, 3'd7, 8'h00, 4'd0, 0, "R1 R3 R8 read bank1 hold0");
      do_op(2'b01, 0, 3'd6, 8'h5A, 4'd3, 0, "R1 R2 R5 R8 write hold3");
      st_lo = 4'h6; st_hi = 4'h9;
      do_op(2'b00, 1, 3'd1, 8'h00, 4'd2, 1, "R9 read with stray start");
      do_op(2'b11, 0, 3'd0, 8'h00, 4'd2, 0, "R7 disconnect restore");
      do_op(2'b01, 1, 3'd0, 8'h33, 4'd5, 0, "R1 R5 R8 write hold5");
      do_op(2'b10, 0, 3'd0, 8'h00, 4'd1, 0, "R6 connect after write");
      do_op(2'b11, 0, 3'd0, 8'h00, 4'd1, 0, "R7 disconnect second");

      repeat (3) @(negedge clk);
      // R10 idle quiet: lines hold the restored values
      chk(pp_data == 8'h33, "R10 idle data", pp_data, 8'h33);
      chk(pp_ctrl == 4'h4, "R10 idle ctrl", pp_ctrl, 4'h4);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule